// File: doc/BRIEF.md
# Translation Lookaside Buffer with Page-Table Walk

This block converts a virtual address into a physical address. The address is split into a virtual page number and a page offset. The page number is looked up in a small set-associative cache of recent translations. On a hit, the stored physical block number is joined with the unchanged offset. A write to a page that is not yet marked dirty also updates the page-table entry in memory before the response is given.

On a miss, the block fetches one entry from a flat page table held in memory. The entry's address is the table base plus four times the page number. A present entry is installed in the cache, and the lookup is then repeated, so the translation always completes from the cache. An absent entry is never installed and returns a page-fault code.

A write to a read-only page returns a protection-fault code. The non-cacheable attribute travels out with each successful translation. Requests are taken one at a time: the block holds `busy` high from acceptance until it issues a single-cycle response. A flush input invalidates every cached translation at once.

Top module: `pt_tlb`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `mem_req` are low and no translation is cached, so the first access to any page reads memory.
- R2: A hit returns `resp_fault` = 0 and `resp_pa` = {block number, page offset}, with no memory access for reads or for writes to already-dirty pages.
- R3: A miss issues exactly one memory read at `pt_base + 4*VPN`. The entry word has bit 0 = present, bit 1 = read-only, bit 2 = non-cacheable, bit 3 = dirty, and the block number in bits [PTE_W-1:4].
- R4: A present entry fetched on a miss is installed before the response, so the next access to the same page needs no memory read; a page never matches more than one way.
- R5: An entry with present = 0 gives `resp_fault` = 1 and is not installed, so a repeated access reads memory again.
- R6: A write to a read-only page gives `resp_fault` = 2; reads of the same page translate normally.
- R7: `resp_nocache` equals the entry's non-cacheable bit on every successful translation.
- R8: A write to a clean, writable page causes one memory write at the entry's address. The written word has the dirty bit set and the other fields unchanged. Later writes to that page cause no memory access.
- R9: A miss installs into the lowest-numbered invalid way of its set, or, if all ways are valid, into the least recently used way.
- R10: `flush` invalidates all cached translations in one cycle.
- R11: `mem_req` stays asserted, with address and direction stable, until `mem_ack`, and only one memory access is outstanding at a time. `busy` is high from acceptance to response, and `resp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_base | input | PA_W | Byte address of the page table |
| req_valid | input | 1 | Translation request, taken when `busy` is low |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | Request is a write access |
| busy | output | 1 | Request in progress |
| resp_valid | output | 1 | Response pulse |
| resp_pa | output | PA_W | Physical address |
| resp_fault | output | 2 | 0 none, 1 page absent, 2 write to read-only page |
| resp_nocache | output | 1 | Non-cacheable attribute |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | PA_W | Page-table entry byte address |
| mem_wdata | output | PTE_W | Entry word to write |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | PTE_W | Entry word read, valid with `mem_ack` |

## Verification
The embedded assertions check several properties on every cycle:
- the memory handshake holds steady until acknowledged;
- responses last a single cycle;
- no tag matches two ways;
- the replacement ages of every set stay a permutation;
- fills happen only from present entries;
- write-backs carry the dirty bit.

Other behaviours only show up across the bench's request sequences:
- correct physical addresses and fault codes;
- the count and address of memory reads, which separate hits from misses;
- which page LRU eviction removes;
- the effect of flush;
- the dirty state finally left in the memory-side table.

// File: rtl/pt_tlb_pkg.sv
package pt_tlb_pkg;

  // Page-table entry flag positions (block number sits above bit 3)
  localparam int PTE_P  = 0;
  localparam int PTE_RO = 1;
  localparam int PTE_NC = 2;
  localparam int PTE_D  = 3;
  localparam int PTE_FLAGS = 4;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FETCH,
    ST_WBACK
  } walk_st_e;

endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 16,
  parameter int PFN_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [$clog2(SETS)-1:0]  lk_set,
  input  logic [TAG_W-1:0]         lk_tag,
  output logic                     hit,
  output logic [$clog2(WAYS)-1:0]  hit_way,
  output logic [PFN_W-1:0]         hit_pfn,
  output logic                     hit_ro,
  output logic                     hit_nc,
  output logic                     hit_dirty,
  output logic [WAYS-1:0]          set_valid,
  input  logic                     fill_en,
  input  logic [$clog2(WAYS)-1:0]  fill_way,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic [PFN_W-1:0]         fill_pfn,
  input  logic                     fill_ro,
  input  logic                     fill_nc,
  input  logic                     fill_dirty,
  input  logic                     mark_en,
  input  logic [$clog2(WAYS)-1:0]  mark_way
);

  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  match;
  logic [PFN_W-1:0] way_pfn [WAYS];
  logic [WAYS-1:0]  way_ro;
  logic [WAYS-1:0]  way_nc;
  logic [WAYS-1:0]  way_dty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [PFN_W-1:0] pfn_q [SETS];
    logic [SETS-1:0]  ro_q;
    logic [SETS-1:0]  nc_q;
    logic [SETS-1:0]  dty_q;
    logic             sel_fill;
    logic             sel_mark;

    assign sel_fill = fill_en && (fill_way == WAY_W'(w));
    assign sel_mark = mark_en && (mark_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (flush) begin
        vld_q <= '0;
      end else if (sel_fill) begin
        vld_q[lk_set] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_fill) begin
        tag_q[lk_set] <= fill_tag;
        pfn_q[lk_set] <= fill_pfn;
        ro_q[lk_set]  <= fill_ro;
        nc_q[lk_set]  <= fill_nc;
        dty_q[lk_set] <= fill_dirty;
      end else if (sel_mark) begin
        dty_q[lk_set] <= 1'b1;
      end
    end

    assign match[w]     = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    assign set_valid[w] = vld_q[lk_set];
    assign way_pfn[w]   = pfn_q[lk_set];
    assign way_ro[w]    = ro_q[lk_set];
    assign way_nc[w]    = nc_q[lk_set];
    assign way_dty[w]   = dty_q[lk_set];
  end

  always_comb begin
    hit_way   = '0;
    hit_pfn   = '0;
    hit_ro    = 1'b0;
    hit_nc    = 1'b0;
    hit_dirty = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        hit_way   = WAY_W'(w);
        hit_pfn   = way_pfn[w];
        hit_ro    = way_ro[w];
        hit_nc    = way_nc[w];
        hit_dirty = way_dty[w];
      end
    end
  end

  assign hit = |match;

  // R4: a refill never leaves a page cached in two ways of one set
  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] set_idx,
  input  logic [WAYS-1:0]         set_valid,
  input  logic                    touch_en,
  input  logic [$clog2(WAYS)-1:0] touch_way,
  output logic [$clog2(WAYS)-1:0] victim
);

  localparam int WAY_W = $clog2(WAYS);
  localparam int AGE_W = WAY_W;

  logic [AGE_W-1:0] age_q   [SETS][WAYS];
  logic [AGE_W-1:0] age_nxt [WAYS];
  logic [WAYS-1:0]  oldest;
  logic [WAY_W-1:0] inv_way;
  logic [WAY_W-1:0] old_way;

  // Touched way becomes youngest; younger ways age by one
  always_comb begin
    for (int v = 0; v < WAYS; v++) begin
      if (WAY_W'(v) == touch_way) begin
        age_nxt[v] = '0;
      end else if (age_q[set_idx][v] < age_q[set_idx][touch_way]) begin
        age_nxt[v] = age_q[set_idx][v] + 1'b1;
      end else begin
        age_nxt[v] = age_q[set_idx][v];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int v = 0; v < WAYS; v++) begin
          age_q[s][v] <= AGE_W'(v);
        end
      end
    end else if (touch_en) begin
      for (int v = 0; v < WAYS; v++) begin
        age_q[set_idx][v] <= age_nxt[v];
      end
    end
  end

  always_comb begin
    inv_way = '0;
    old_way = '0;
    for (int v = WAYS - 1; v >= 0; v--) begin
      oldest[v] = (age_q[set_idx][v] == AGE_W'(WAYS - 1));
      if (!set_valid[v]) inv_way = WAY_W'(v);
      if (oldest[v])     old_way = WAY_W'(v);
    end
  end

  assign victim = (&set_valid) ? old_way : inv_way;

  // R9: ages within the addressed set stay a permutation with one oldest way
  assert_lru_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);

endmodule

// File: rtl/tlb_walk_fsm.sv
module tlb_walk_fsm
  import pt_tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int WAYS   = 4,
  parameter int SETS   = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [PA_W-1:0]                   pt_base,
  input  logic                              req_valid,
  input  logic [VA_W-1:0]                   req_va,
  input  logic                              req_write,
  output logic                              busy,
  output logic                              resp_valid,
  output logic [PA_W-1:0]                   resp_pa,
  output logic [1:0]                        resp_fault,
  output logic                              resp_nocache,
  output logic                              mem_req,
  output logic                              mem_we,
  output logic [PA_W-1:0]                   mem_addr,
  output logic [PA_W-PAGE_W+PTE_FLAGS-1:0]  mem_wdata,
  input  logic                              mem_ack,
  input  logic [PA_W-PAGE_W+PTE_FLAGS-1:0]  mem_rdata,
  output logic [$clog2(SETS)-1:0]           lk_set,
  output logic [VA_W-PAGE_W-$clog2(SETS)-1:0] lk_tag,
  input  logic                              hit,
  input  logic [$clog2(WAYS)-1:0]           hit_way,
  input  logic [PA_W-PAGE_W-1:0]            hit_pfn,
  input  logic                              hit_ro,
  input  logic                              hit_nc,
  input  logic                              hit_dirty,
  input  logic [$clog2(WAYS)-1:0]           victim,
  output logic                              fill_en,
  output logic [$clog2(WAYS)-1:0]           fill_way,
  output logic [PA_W-PAGE_W-1:0]            fill_pfn,
  output logic                              fill_ro,
  output logic                              fill_nc,
  output logic                              fill_dirty,
  output logic                              mark_en,
  output logic [$clog2(WAYS)-1:0]           mark_way,
  output logic                              touch_en,
  output logic [$clog2(WAYS)-1:0]           touch_way
);

  localparam int PFN_W = PA_W - PAGE_W;
  localparam int PTE_W = PFN_W + PTE_FLAGS;
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - SET_W;

  walk_st_e         state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic             we_q;
  logic             rsp_vld_q;
  logic [PA_W-1:0]  rsp_pa_q, pa_d;
  fault_e           rsp_flt_q, flt_d;
  logic             rsp_nc_q, nc_d;
  logic [PTE_W-1:0] wb_q, wb_d;
  logic             acc, rsp_load, rsp_fire, wb_load;
  logic [VPN_W-1:0] vpn;

  assign vpn    = va_q[VA_W-1:PAGE_W];
  assign lk_set = va_q[PAGE_W +: SET_W];
  assign lk_tag = va_q[VA_W-1 -: TAG_W];

  // Next-state and datapath enables
  always_comb begin
    state_d  = state_q;
    acc      = 1'b0;
    rsp_load = 1'b0;
    rsp_fire = 1'b0;
    wb_load  = 1'b0;
    fill_en  = 1'b0;
    mark_en  = 1'b0;
    touch_en = 1'b0;
    flt_d    = FLT_NONE;
    pa_d     = {hit_pfn, va_q[PAGE_W-1:0]};
    nc_d     = hit_nc;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          acc     = 1'b1;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit) begin
          touch_en = 1'b1;
          rsp_load = 1'b1;
          if (we_q && hit_ro) begin
            flt_d    = FLT_PROT;
            pa_d     = '0;
            nc_d     = 1'b0;
            rsp_fire = 1'b1;
            state_d  = ST_IDLE;
          end else if (we_q && !hit_dirty) begin
            mark_en = 1'b1;
            wb_load = 1'b1;
            state_d = ST_WBACK;
          end else begin
            rsp_fire = 1'b1;
            state_d  = ST_IDLE;
          end
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (!mem_rdata[PTE_P]) begin
            rsp_load = 1'b1;
            rsp_fire = 1'b1;
            flt_d    = FLT_ABSENT;
            pa_d     = '0;
            nc_d     = 1'b0;
            state_d  = ST_IDLE;
          end else begin
            fill_en = 1'b1;
            state_d = ST_LOOK;
          end
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          rsp_fire = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wb_d = '0;
    wb_d[PTE_W-1 -: PFN_W] = hit_pfn;
    wb_d[PTE_D]  = 1'b1;
    wb_d[PTE_NC] = hit_nc;
    wb_d[PTE_RO] = hit_ro;
    wb_d[PTE_P]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_vld_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_vld_q <= rsp_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      va_q <= req_va;
      we_q <= req_write;
    end
    if (rsp_load) begin
      rsp_pa_q  <= pa_d;
      rsp_flt_q <= flt_d;
      rsp_nc_q  <= nc_d;
    end
    if (wb_load) begin
      wb_q <= wb_d;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign resp_valid   = rsp_vld_q;
  assign resp_pa      = rsp_pa_q;
  assign resp_fault   = rsp_flt_q;
  assign resp_nocache = rsp_nc_q;

  assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_WBACK);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = pt_base + (PA_W'(vpn) << 2);
  assign mem_wdata = (state_q == ST_WBACK) ? wb_q : '0;

  assign fill_way   = victim;
  assign fill_pfn   = mem_rdata[PTE_W-1 -: PFN_W];
  assign fill_ro    = mem_rdata[PTE_RO];
  assign fill_nc    = mem_rdata[PTE_NC];
  assign fill_dirty = mem_rdata[PTE_D];
  assign mark_way   = hit_way;
  assign touch_way  = hit_way;

  // R11: an open memory request keeps address and direction until acknowledged
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R11: the response lasts exactly one cycle
  assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R5: only present entries are installed
  assert_fill_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> mem_rdata[PTE_P]);

  // R6: protection faults come only from write requests
  assert_prot_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_fault == FLT_PROT) |-> we_q);

  // R8: memory writes are dirty-marking write-backs for write requests
  assert_wb_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[PTE_D] && mem_wdata[PTE_P] && we_q);

endmodule

// File: rtl/pt_tlb.sv
module pt_tlb
  import pt_tlb_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int WAYS   = 4,
  parameter int SETS   = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic [PA_W-1:0]                  pt_base,
  input  logic                             req_valid,
  input  logic [VA_W-1:0]                  req_va,
  input  logic                             req_write,
  output logic                             busy,
  output logic                             resp_valid,
  output logic [PA_W-1:0]                  resp_pa,
  output logic [1:0]                       resp_fault,
  output logic                             resp_nocache,
  output logic                             mem_req,
  output logic                             mem_we,
  output logic [PA_W-1:0]                  mem_addr,
  output logic [PA_W-PAGE_W+PTE_FLAGS-1:0] mem_wdata,
  input  logic                             mem_ack,
  input  logic [PA_W-PAGE_W+PTE_FLAGS-1:0] mem_rdata
);

  localparam int PFN_W = PA_W - PAGE_W;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VA_W - PAGE_W - SET_W;

  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [PFN_W-1:0] hit_pfn;
  logic             hit_ro, hit_nc, hit_dirty;
  logic [WAYS-1:0]  set_valid;
  logic [WAY_W-1:0] victim;
  logic             fill_en;
  logic [WAY_W-1:0] fill_way;
  logic [PFN_W-1:0] fill_pfn;
  logic             fill_ro, fill_nc, fill_dirty;
  logic             mark_en;
  logic [WAY_W-1:0] mark_way;
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;

  tlb_tag_array #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .PFN_W(PFN_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_set(lk_set), .lk_tag(lk_tag),
    .hit(hit), .hit_way(hit_way), .hit_pfn(hit_pfn),
    .hit_ro(hit_ro), .hit_nc(hit_nc), .hit_dirty(hit_dirty),
    .set_valid(set_valid),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(lk_tag),
    .fill_pfn(fill_pfn), .fill_ro(fill_ro), .fill_nc(fill_nc),
    .fill_dirty(fill_dirty),
    .mark_en(mark_en), .mark_way(mark_way)
  );

  tlb_lru #(
    .WAYS(WAYS), .SETS(SETS)
  ) u_lru (
    .clk(clk), .rst_n(rst_n), .set_idx(lk_set), .set_valid(set_valid),
    .touch_en(touch_en), .touch_way(touch_way), .victim(victim)
  );

  tlb_walk_fsm #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .WAYS(WAYS), .SETS(SETS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
    .busy(busy), .resp_valid(resp_valid), .resp_pa(resp_pa),
    .resp_fault(resp_fault), .resp_nocache(resp_nocache),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lk_set(lk_set), .lk_tag(lk_tag),
    .hit(hit), .hit_way(hit_way), .hit_pfn(hit_pfn),
    .hit_ro(hit_ro), .hit_nc(hit_nc), .hit_dirty(hit_dirty),
    .victim(victim),
    .fill_en(fill_en), .fill_way(fill_way), .fill_pfn(fill_pfn),
    .fill_ro(fill_ro), .fill_nc(fill_nc), .fill_dirty(fill_dirty),
    .mark_en(mark_en), .mark_way(mark_way),
    .touch_en(touch_en), .touch_way(touch_way)
  );

endmodule

// File: tb/pt_tlb_tb.sv
module pt_tlb_tb;

  localparam logic [31:0] BASE = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic [31:0] pt_base;
  logic        req_valid;
  logic [31:0] req_va;
  logic        req_write;
  logic        busy, resp_valid, resp_nocache;
  logic [31:0] resp_pa;
  logic [1:0]  resp_fault;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [23:0] mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr;
  logic [23:0] last_wdata;
  bit dirty_mem [1024];

  logic [1:0]  got_flt;
  logic [31:0] got_pa;
  logic        got_nc;
  int          d_rd, d_wr;

  always #2 clk = ~clk;

  pt_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write),
    .busy(busy), .resp_valid(resp_valid), .resp_pa(resp_pa),
    .resp_fault(resp_fault), .resp_nocache(resp_nocache),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [23:0] pte_word(int vpn);
    logic [23:0] w;
    w        = '0;
    w[23:4]  = 20'(vpn * 37 + 100);
    w[3]     = dirty_mem[vpn];
    w[2]     = (vpn % 3 == 0);
    w[1]     = (vpn % 5 == 1);
    w[0]     = (vpn % 7 != 3);
    return w;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Page-table memory responder
  initial begin
    int lat;
    int idx;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        lat = $urandom % 3;
        repeat (lat) @(negedge clk);
        idx = int'((mem_addr - BASE) >> 2);
        if (idx < 0 || idx > 1023) idx = 0;
        if (mem_we) begin
          wr_cnt++;
          last_wr_addr   = mem_addr;
          last_wdata     = mem_wdata;
          dirty_mem[idx] = mem_wdata[3];
        end else begin
          rd_cnt++;
          last_rd_addr = mem_addr;
        end
        mem_rdata = pte_word(idx);
        mem_ack   = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic do_req(int vpn, int off, bit we);
    int r0, w0;
    r0 = rd_cnt;
    w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = {20'(vpn), 12'(off)};
    req_write = we;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy after accept", 64'(busy), 64'(1));
    while (!resp_valid) @(negedge clk);
    got_flt = resp_fault;
    got_pa  = resp_pa;
    got_nc  = resp_nocache;
    d_rd    = rd_cnt - r0;
    d_wr    = wr_cnt - w0;
    @(negedge clk);
    chk("R11 single-cycle response", 64'(resp_valid), 64'(0));
  endtask

  task automatic expect_xlat(int vpn, int off, bit we, string tag);
    logic [23:0] p;
    logic [1:0]  ef;
    p  = pte_word(vpn);
    ef = !p[0] ? 2'd1 : (we && p[1]) ? 2'd2 : 2'd0;
    chk({tag, " fault"}, 64'(got_flt), 64'(ef));
    if (ef == 2'd0) begin
      chk({tag, " pa"}, 64'(got_pa), 64'({p[23:4], 12'(off)}));
      chk({tag, " R7 nocache"}, 64'(got_nc), 64'(p[2]));
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n     = 1'b0;
    flush     = 1'b0;
    pt_base   = BASE;
    req_valid = 1'b0;
    req_va    = '0;
    req_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle outputs after reset
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 resp_valid", 64'(resp_valid), 64'(0));
    chk("R1 mem_req", 64'(mem_req), 64'(0));

    // R1 / R3: first access misses and reads the entry address
    do_req(9, 12'h345, 1'b0);
    expect_xlat(9, 12'h345, 1'b0, "R2");
    chk("R1 R3 one read on miss", 64'(d_rd), 64'(1));
    chk("R3 entry address", 64'(last_rd_addr), 64'(BASE + 32'd36));
    // R4: refilled page now hits
    do_req(9, 12'h0ff, 1'b0);
    expect_xlat(9, 12'h0ff, 1'b0, "R2");
    chk("R4 hit needs no read", 64'(d_rd), 64'(0));

    // R5: absent page faults and is not cached
    do_req(3, 12'h010, 1'b0);
    chk("R5 absent fault", 64'(got_flt), 64'(1));
    do_req(3, 12'h010, 1'b0);
    chk("R5 no fill, reread", 64'(d_rd), 64'(1));

    // R6: read-only page
    do_req(1, 12'h020, 1'b1);
    chk("R6 protection fault", 64'(got_flt), 64'(2));
    chk("R6 no write-back", 64'(d_wr), 64'(0));
    do_req(1, 12'h020, 1'b0);
    expect_xlat(1, 12'h020, 1'b0, "R6 read of ro page");

    // R8: dirty marking on first write to a clean page
    do_req(2, 12'h7a0, 1'b1);
    expect_xlat(2, 12'h7a0, 1'b1, "R8");
    chk("R8 one write-back", 64'(d_wr), 64'(1));
    chk("R8 write-back address", 64'(last_wr_addr), 64'(BASE + 32'd8));
    chk("R8 write-back word", 64'(last_wdata), 64'({20'(2 * 37 + 100), 4'b1001}));
    do_req(2, 12'h7a4, 1'b1);
    chk("R8 second write no traffic", 64'(d_wr + d_rd), 64'(0));

    // R10: flush forgets cached page
    do_flush();
    do_req(9, 12'h001, 1'b0);
    chk("R10 miss after flush", 64'(d_rd), 64'(1));

    // R9: LRU eviction within set 2
    do_flush();
    do_req(2, 0, 1'b0);
    do_req(18, 0, 1'b0);
    do_req(34, 0, 1'b0);
    do_req(50, 0, 1'b0);
    chk("R9 fourth fill used an invalid way", 64'(d_rd), 64'(1));
    do_req(2, 0, 1'b0);
    chk("R9 resident after filling ways", 64'(d_rd), 64'(0));
    do_req(82, 0, 1'b0);
    chk("R9 fifth page misses", 64'(d_rd), 64'(1));
    do_req(2, 0, 1'b0);
    chk("R9 recently used page kept", 64'(d_rd), 64'(0));
    do_req(34, 0, 1'b0);
    chk("R9 other page kept", 64'(d_rd), 64'(0));
    do_req(18, 0, 1'b0);
    chk("R9 least recent page evicted", 64'(d_rd), 64'(1));

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      int vpn, off;
      bit we, dbefore;
      logic [23:0] p;
      vpn     = $urandom % 96;
      off     = $urandom % 4096;
      we      = 1'($urandom % 2);
      dbefore = dirty_mem[vpn];
      p       = pte_word(vpn);
      do_req(vpn, off, we);
      expect_xlat(vpn, off, we, "R2 random");
      if (we && p[0] && !p[1]) begin
        chk("R8 random write-back count", 64'(d_wr), 64'(dbefore ? 0 : 1));
        chk("R8 random dirty in memory", 64'(dirty_mem[vpn]), 64'(1));
      end else begin
        chk("R8 random no write-back", 64'(d_wr), 64'(0));
      end
      if (!p[0]) chk("R5 random absent reads", 64'(d_rd), 64'(1));
    end

    finish_run();
  end

endmodule